// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block runs single write transactions into an external asynchronous static RAM of 128K bytes. The RAM has two chip enables of opposite sense (`mem_sel_n_o`, active low, and `mem_sel_o`, active high) and an active-low write strobe `mem_wr_n_o`. Its output enable is tied low on the board. A write lands in the RAM only while all three controls are asserted together. The user raises `start_i` for one clock with a 17-bit address and a byte. The sequencer reports `busy_o` while the cycle runs and pulses `done_o` when the address may change again.

All RAM timing is counted in whole system clocks. Each interval is a parameter of at least 1: address setup, write pulse width, data setup, enable-to-end width, data hold, and two recovery values. The write strobe always falls before the low-active enable, so the RAM never turns its outputs on while the controller drives data. The write window then opens on the falling edge of `mem_sel_n_o`. The parameter `CLOSE_ON_SEL` picks the signal that closes the window. When it is 0, the strobe rises while both enables stay on, and recovery `T_REC_WR` applies. When it is 1, `mem_sel_o` falls while the strobe stays low, and recovery `T_REC_SEL` applies. In both variants every control returns to idle one clock after the window closes. The sequencer also owns `mem_dq_oe_o`, the direction control of the shared data bus.

States are `ST_IDLE`, `ST_SETUP`, `ST_STROBE`, `ST_CLOSE`, `ST_HOLD`, `ST_RECOVER` and `ST_FINISH`. The transitions are:
- `ST_IDLE`→`ST_SETUP` on an accepted start.
- `ST_SETUP`→`ST_STROBE` after the setup count.
- `ST_STROBE`→`ST_CLOSE` after the pulse count.
- `ST_CLOSE` goes to `ST_HOLD` if hold is longer than one clock, else to `ST_RECOVER` if recovery is still owed, else to `ST_FINISH`.
- `ST_HOLD` goes to `ST_RECOVER` if recovery is still owed, else to `ST_FINISH`.
- `ST_RECOVER`→`ST_FINISH` after the count.
- `ST_FINISH`→`ST_IDLE` unconditionally.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset, `mem_sel_n_o`=1, `mem_sel_o`=0, `mem_wr_n_o`=1, `mem_dq_oe_o`=0, `busy_o`=0 and `done_o`=0.
- R2: When `start_i` is sampled high in idle, the sequencer captures `addr_i` and `wdata_i`. From the next clock, `busy_o`=1 and `mem_addr_o` shows the captured address. In that same clock `mem_wr_n_o`=0, `mem_sel_o`=1 and `mem_sel_n_o`=1.
- R3: `mem_addr_o` holds its value from the clock after acceptance until `done_o` has been shown.
- R4: `mem_wr_n_o` is low for exactly `T_ADDR_SU` clocks before `mem_sel_n_o` falls, and it is never high when `mem_sel_n_o` falls.
- R5: The write window (`mem_sel_n_o`=0, `mem_sel_o`=1, `mem_wr_n_o`=0) lasts exactly max(`T_PULSE`, `T_DATA_SU`, `T_SEL_END`) clocks. Throughout it, `mem_dq_oe_o`=1 and `mem_dq_o` equals the captured byte.
- R6: `mem_dq_oe_o` is high during the window and for exactly `T_DATA_HOLD` clocks after it closes, and low at all other times.
- R7: With `CLOSE_ON_SEL`=0, the window closes with `mem_wr_n_o` rising while `mem_sel_n_o`=0 and `mem_sel_o`=1. One clock later, `mem_sel_n_o`=1 and `mem_sel_o`=0.
- R8: With `CLOSE_ON_SEL`=1, the window closes with `mem_sel_o` falling while `mem_sel_n_o`=0 and `mem_wr_n_o`=0. One clock later, `mem_sel_n_o`=1 and `mem_wr_n_o`=1.
- R9: `done_o` is high for exactly one clock. It comes max(`T_DATA_HOLD`, R) clocks after the first clock with the window closed, where R is `T_REC_WR` when `CLOSE_ON_SEL`=0 and `T_REC_SEL` when it is 1.
- R10: A `start_i` pulse while `busy_o`=1 is ignored: no extra write occurs, and the address and data of the running write are unchanged.
- R11: A start in the first idle clock after `done_o` is accepted, so back-to-back writes work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled in idle |
| addr_i | input | 17 | Write address |
| wdata_i | input | 8 | Write byte |
| busy_o | output | 1 | A write cycle is running |
| done_o | output | 1 | One-clock completion pulse |
| mem_addr_o | output | 17 | Address lines to the RAM |
| mem_dq_o | output | 8 | Data driven toward the RAM |
| mem_dq_oe_o | output | 1 | Data bus direction: 1 drives, 0 releases |
| mem_sel_n_o | output | 1 | Active-low chip enable |
| mem_sel_o | output | 1 | Active-high chip enable |
| mem_wr_n_o | output | 1 | Active-low write strobe |

## Verification
The assertions assume that reset is held low for at least one clock before the first transaction. They also assume `start_i` is a single-clock pulse, since a level held through `done_o` would start a second write in the next idle clock. The address and data inputs are assumed meaningful only in the clock where the start is sampled. The stimulus drives only single-clock start pulses and changes inputs on the falling clock edge. It issues the start that is meant to be ignored well inside a running cycle, with an address and byte that differ from the running write, so the bench can see that the running write keeps its own values.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_CLOSE,
        ST_HOLD,
        ST_RECOVER,
        ST_FINISH
    } wr_state_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic wr_n;
        logic dq_oe;
    } pin_set_t;

    localparam pin_set_t PINS_IDLE = '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1, dq_oe: 1'b0};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wr_ticker.sv
module sram_wr_ticker #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    AST_TICK_REST_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && zero_o) |=> zero_o); // R5

endmodule

// File: rtl/sram_wr_datapath.sv
module sram_wr_datapath #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              dq_oe_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_dq_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (capture_i) begin
            addr_q <= addr_i;
            data_q <= wdata_i;
        end
    end

    assign mem_addr_o = addr_q;
    assign mem_dq_o   = dq_oe_i ? data_q : '0;

    AST_DATA_STEADY_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe_i && $past(dq_oe_i)) |-> $stable(mem_dq_o)); // R5

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
    import sram_wr_pkg::*;
#(
    parameter bit CLOSE_ON_SEL = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  wr_state_e state_d_i,
    output pin_set_t  pins_o
);

    pin_set_t close_pins;
    pin_set_t pins_d;
    pin_set_t pins_q;

    generate
        if (CLOSE_ON_SEL) begin : g_close_sel
            assign close_pins = '{sel_n: 1'b0, sel: 1'b0, wr_n: 1'b0, dq_oe: 1'b1};
        end else begin : g_close_wr
            assign close_pins = '{sel_n: 1'b0, sel: 1'b1, wr_n: 1'b1, dq_oe: 1'b1};
        end
    endgenerate

    always_comb begin
        pins_d = PINS_IDLE;
        unique case (state_d_i)
            ST_IDLE:    pins_d = PINS_IDLE;
            ST_SETUP:   pins_d = '{sel_n: 1'b1, sel: 1'b1, wr_n: 1'b0, dq_oe: 1'b0};
            ST_STROBE:  pins_d = '{sel_n: 1'b0, sel: 1'b1, wr_n: 1'b0, dq_oe: 1'b1};
            ST_CLOSE:   pins_d = close_pins;
            ST_HOLD:    pins_d = '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1, dq_oe: 1'b1};
            ST_RECOVER: pins_d = '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1, dq_oe: 1'b0};
            ST_FINISH:  pins_d = PINS_IDLE;
            default:    pins_d = PINS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= PINS_IDLE;
        end else begin
            pins_q <= pins_d;
        end
    end

    assign pins_o = pins_q;

    AST_WR_LEADS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pins_q.sel_n) |-> $past(!pins_q.wr_n)); // R4

    AST_BUS_DRIVEN_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!pins_q.sel_n && pins_q.sel && !pins_q.wr_n) |-> pins_q.dq_oe); // R6

    AST_BUS_OFF_WHILE_UNSELECTED_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_q.sel_n && !pins_q.wr_n) |-> !pins_q.dq_oe); // R6

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 17,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned T_ADDR_SU   = 2,
    parameter int unsigned T_PULSE     = 3,
    parameter int unsigned T_DATA_SU   = 2,
    parameter int unsigned T_SEL_END   = 4,
    parameter int unsigned T_DATA_HOLD = 2,
    parameter int unsigned T_REC_WR    = 3,
    parameter int unsigned T_REC_SEL   = 5,
    parameter bit          CLOSE_ON_SEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe_o,
    output logic              mem_sel_n_o,
    output logic              mem_sel_o,
    output logic              mem_wr_n_o
);

    localparam int unsigned STROBE_LEN = max2(max2(T_PULSE, T_DATA_SU), T_SEL_END);
    localparam int unsigned REC_SEL    = CLOSE_ON_SEL ? T_REC_SEL : T_REC_WR;
    localparam int unsigned TAIL_LEN   = max2(T_DATA_HOLD, REC_SEL);
    localparam int unsigned REC_EXTRA  = TAIL_LEN - T_DATA_HOLD;
    localparam int unsigned CNT_MAX    = max2(max2(T_ADDR_SU, STROBE_LEN), TAIL_LEN);
    localparam int unsigned CNT_W      = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(T_ADDR_SU - 1);
    localparam logic [CNT_W-1:0] LD_STROBE = CNT_W'(STROBE_LEN - 1);
    localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'((T_DATA_HOLD > 1) ? T_DATA_HOLD - 2 : 0);
    localparam logic [CNT_W-1:0] LD_REC    = CNT_W'((REC_EXTRA > 0) ? REC_EXTRA - 1 : 0);

    wr_state_e        state_q;
    wr_state_e        state_d;
    logic             tick_load;
    logic [CNT_W-1:0] tick_val;
    logic             tick_zero;
    logic             accept;
    pin_set_t         pins;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and interval loads
    always_comb begin
        state_d   = state_q;
        tick_load = 1'b0;
        tick_val  = '0;
        accept    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept    = 1'b1;
                    state_d   = ST_SETUP;
                    tick_load = 1'b1;
                    tick_val  = LD_SETUP;
                end
            end
            ST_SETUP: begin
                if (tick_zero) begin
                    state_d   = ST_STROBE;
                    tick_load = 1'b1;
                    tick_val  = LD_STROBE;
                end
            end
            ST_STROBE: begin
                if (tick_zero) begin
                    state_d = ST_CLOSE;
                end
            end
            ST_CLOSE: begin
                if (T_DATA_HOLD > 1) begin
                    state_d   = ST_HOLD;
                    tick_load = 1'b1;
                    tick_val  = LD_HOLD;
                end else if (REC_EXTRA > 0) begin
                    state_d   = ST_RECOVER;
                    tick_load = 1'b1;
                    tick_val  = LD_REC;
                end else begin
                    state_d = ST_FINISH;
                end
            end
            ST_HOLD: begin
                if (tick_zero) begin
                    if (REC_EXTRA > 0) begin
                        state_d   = ST_RECOVER;
                        tick_load = 1'b1;
                        tick_val  = LD_REC;
                    end else begin
                        state_d = ST_FINISH;
                    end
                end
            end
            ST_RECOVER: begin
                if (tick_zero) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // user-side flags
    always_comb begin
        busy_o = (state_q != ST_IDLE);
        done_o = (state_q == ST_FINISH);
    end

    sram_wr_ticker #(
        .CNT_W (CNT_W)
    ) u_ticker (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tick_load),
        .load_val_i (tick_val),
        .zero_o     (tick_zero)
    );

    sram_wr_pins #(
        .CLOSE_ON_SEL (CLOSE_ON_SEL)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_d_i (state_d),
        .pins_o    (pins)
    );

    sram_wr_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  (accept),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .dq_oe_i    (pins.dq_oe),
        .mem_addr_o (mem_addr_o),
        .mem_dq_o   (mem_dq_o)
    );

    assign mem_sel_n_o = pins.sel_n;
    assign mem_sel_o   = pins.sel;
    assign mem_wr_n_o  = pins.wr_n;
    assign mem_dq_oe_o = pins.dq_oe;

    AST_ADDR_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mem_addr_o)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(mem_addr_o)); // R10

    AST_PINS_IDLE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (mem_sel_n_o && !mem_sel_o && mem_wr_n_o && !mem_dq_oe_o)); // R1

endmodule

// File: tb/sim_sram_wr_seq.sv
`timescale 1ns/1ps
module sim_sram_wr_seq;

    localparam int AS[2]  = '{2, 1};
    localparam int PW[2]  = '{3, 2};
    localparam int DS[2]  = '{2, 3};
    localparam int CW[2]  = '{4, 1};
    localparam int DH[2]  = '{2, 1};
    localparam int RW[2]  = '{3, 2};
    localparam int RS[2]  = '{5, 4};
    localparam bit CS[2]  = '{1'b0, 1'b1};

    typedef struct {
        logic [16:0] a;
        logic [7:0]  v;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic        start [2];
    logic [16:0] addr  [2];
    logic [7:0]  wdata [2];
    logic        busy  [2];
    logic        done  [2];
    logic [16:0] maddr [2];
    logic [7:0]  mdq   [2];
    logic        moe   [2];
    logic        sel_n [2];
    logic        sel   [2];
    logic        wr_n  [2];

    int n_chk = 0;
    int n_bad = 0;
    exp_t q0[$];
    exp_t q1[$];

    always #2 clk = ~clk;

    sram_wr_seq #(
        .T_ADDR_SU(AS[0]), .T_PULSE(PW[0]), .T_DATA_SU(DS[0]), .T_SEL_END(CW[0]),
        .T_DATA_HOLD(DH[0]), .T_REC_WR(RW[0]), .T_REC_SEL(RS[0]), .CLOSE_ON_SEL(CS[0])
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start[0]), .addr_i(addr[0]), .wdata_i(wdata[0]),
        .busy_o(busy[0]), .done_o(done[0]), .mem_addr_o(maddr[0]), .mem_dq_o(mdq[0]),
        .mem_dq_oe_o(moe[0]), .mem_sel_n_o(sel_n[0]), .mem_sel_o(sel[0]), .mem_wr_n_o(wr_n[0])
    );

    sram_wr_seq #(
        .T_ADDR_SU(AS[1]), .T_PULSE(PW[1]), .T_DATA_SU(DS[1]), .T_SEL_END(CW[1]),
        .T_DATA_HOLD(DH[1]), .T_REC_WR(RW[1]), .T_REC_SEL(RS[1]), .CLOSE_ON_SEL(CS[1])
    ) u1 (
        .clk(clk), .rst_n(rst_n), .start_i(start[1]), .addr_i(addr[1]), .wdata_i(wdata[1]),
        .busy_o(busy[1]), .done_o(done[1]), .mem_addr_o(maddr[1]), .mem_dq_o(mdq[1]),
        .mem_dq_oe_o(moe[1]), .mem_sel_n_o(sel_n[1]), .mem_sel_o(sel[1]), .mem_wr_n_o(wr_n[1])
    );

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input string tag, input bit ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // driver: waits for idle, pulses start, pushes the expected write
    task automatic do_write(input int d, input logic [16:0] a, input logic [7:0] v);
        exp_t e;
        while (busy[d]) @(negedge clk);
        start[d] = 1'b1;
        addr[d]  = a;
        wdata[d] = v;
        e.a = a;
        e.v = v;
        if (d == 0) q0.push_back(e); else q1.push_back(e);
        @(negedge clk);
        start[d] = 1'b0;
        addr[d]  = ~a;
        wdata[d] = ~v;
        check($sformatf("R2/R11 dut%0d accept", d),
              busy[d] && !wr_n[d] && sel[d] && sel_n[d] && maddr[d] == a,
              {busy[d], wr_n[d], sel[d], sel_n[d]}, 4'b1011);
    endtask

    // stray start in the middle of a running write (R10)
    task automatic stray_start(input int d);
        repeat (2) @(negedge clk);
        start[d] = 1'b1;
        addr[d]  = 17'h15555;
        wdata[d] = 8'h3C;
        @(negedge clk);
        start[d] = 1'b0;
    endtask

    // monitor / scoreboard
    int   setup_c [2] = '{0, 0};
    int   win_c   [2] = '{0, 0};
    int   post_c  [2] = '{0, 0};
    int   oe_c    [2] = '{0, 0};
    bit   prev_w  [2] = '{0, 0};
    bit   in_post [2] = '{0, 0};
    bit   dq_bad  [2] = '{0, 0};
    int   writes  [2] = '{0, 0};
    logic [16:0] cap_a [2];
    logic [7:0]  cap_v [2];

    always @(negedge clk) begin
        if (rst_n) begin
            for (int d = 0; d < 2; d++) begin
                bit w;
                exp_t e;
                w = !sel_n[d] && sel[d] && !wr_n[d];
                if (!wr_n[d] && sel_n[d] && sel[d]) setup_c[d]++;
                if (w) begin
                    if (win_c[d] == 0) begin
                        cap_a[d] = maddr[d];
                        cap_v[d] = mdq[d];
                    end else if (mdq[d] != cap_v[d] || maddr[d] != cap_a[d]) begin
                        dq_bad[d] = 1'b1;
                    end
                    if (!moe[d]) dq_bad[d] = 1'b1;
                    win_c[d]++;
                end
                if (prev_w[d] && !w) begin
                    writes[d]++;
                    if ((d == 0 && q0.size() == 0) || (d == 1 && q1.size() == 0)) begin
                        check($sformatf("R10 dut%0d unexpected write", d), 1'b0, writes[d], 0);
                    end else begin
                        if (d == 0) e = q0.pop_front(); else e = q1.pop_front();
                        check($sformatf("R3 dut%0d address", d), cap_a[d] == e.a, cap_a[d], e.a);
                        check($sformatf("R5 dut%0d data", d), cap_v[d] == e.v, cap_v[d], e.v);
                    end
                    check($sformatf("R4 dut%0d setup clocks", d), setup_c[d] == AS[d], setup_c[d], AS[d]);
                    check($sformatf("R5 dut%0d window clocks", d),
                          win_c[d] == mx(mx(PW[d], DS[d]), CW[d]), win_c[d], mx(mx(PW[d], DS[d]), CW[d]));
                    check($sformatf("R5 dut%0d bus steady", d), !dq_bad[d], dq_bad[d], 0);
                    if (CS[d])
                        check("R8 close on enable", !sel[d] && !sel_n[d] && !wr_n[d],
                              {sel[d], sel_n[d], wr_n[d]}, 3'b000);
                    else
                        check("R7 close on strobe", sel[d] && !sel_n[d] && wr_n[d],
                              {sel[d], sel_n[d], wr_n[d]}, 3'b101);
                    in_post[d] = 1'b1;
                    post_c[d]  = 0;
                    oe_c[d]    = moe[d] ? 1 : 0;
                    win_c[d]   = 0;
                    dq_bad[d]  = 1'b0;
                end else if (in_post[d]) begin
                    post_c[d]++;
                    if (moe[d]) oe_c[d]++;
                    if (post_c[d] == 1)
                        check(CS[d] ? "R8 release" : "R7 release", sel_n[d] && !sel[d] && wr_n[d],
                              {sel_n[d], sel[d], wr_n[d]}, 3'b101);
                    if (done[d]) begin
                        check($sformatf("R9 dut%0d done distance", d),
                              post_c[d] == mx(DH[d], CS[d] ? RS[d] : RW[d]),
                              post_c[d], mx(DH[d], CS[d] ? RS[d] : RW[d]));
                        check($sformatf("R6 dut%0d bus hold clocks", d), oe_c[d] == DH[d], oe_c[d], DH[d]);
                        in_post[d] = 1'b0;
                        setup_c[d] = 0;
                    end
                end
                if (!busy[d] && moe[d])
                    check($sformatf("R6 dut%0d bus driven in idle", d), 1'b0, moe[d], 0);
                prev_w[d] = w;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        for (int d = 0; d < 2; d++) begin
            start[d] = 1'b0;
            addr[d]  = '0;
            wdata[d] = '0;
        end
        repeat (4) @(negedge clk);
        for (int d = 0; d < 2; d++)
            check($sformatf("R1 dut%0d reset pins", d),
                  sel_n[d] && !sel[d] && wr_n[d] && !moe[d] && !busy[d] && !done[d],
                  {sel_n[d], sel[d], wr_n[d], moe[d], busy[d], done[d]}, 6'b101000);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            begin
                do_write(0, 17'h00000, 8'h00);
                do_write(0, 17'h1FFFF, 8'hFF);
                stray_start(0);
                do_write(0, 17'h0AAAA, 8'hA5);
                do_write(0, 17'h12345, 8'h5A);
            end
            begin
                do_write(1, 17'h1FFFF, 8'h81);
                stray_start(1);
                do_write(1, 17'h00001, 8'h7E);
                do_write(1, 17'h10000, 8'hC3);
            end
        join
        while (busy[0] || busy[1]) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R10 dut0 writes seen", writes[0] == 4 && q0.size() == 0, writes[0], 4);
        check("R10 dut1 writes seen", writes[1] == 3 && q1.size() == 0, writes[1], 3);
        finish_run();
    end

endmodule